// File: doc/BRIEF.md
# Multicycle Control Sequencer with Exception Entry

This block is the hardwired controller for a multicycle processor datapath. It steps each instruction through a fetch state and a decode state. From decode it dispatches on the opcode to a short chain of execute, memory and write-back states for loads, stores, register-register ALU operations, OR with a zero-extended immediate, branch-if-equal and jump. In every state it drives the control strobes and multiplexer selects of the datapath. The datapath supplies the opcode, the ALU overflow and zero flags, and a memory wait flag. An external interrupt request and its enable also come in.

Three events leave normal flow and enter a handler. They are an opcode with no defined path, a signed overflow in a register-register operation, and an enabled interrupt request that is pending at an instruction boundary. In each case the controller has the datapath save PC minus 4 into the exception PC register. It loads a fixed cause code and redirects the PC to the handler address. The fetch state and the two data-memory states hold while the memory reports wait. The control outputs are held in flops that load the decode of the next state, so no path runs from state logic to the datapath.

Top module: `mc_ctrl_top`

## Requirements
- R1: While `rst` is high every write or load strobe (`ir_load`, `pc_load`, `mdr_load`, `mem_read`, `mem_write`, `reg_write`, `epc_load`, `cause_load`, `alu_out_load`) is low. The first clock edge with `rst` high puts `state_code` at 0 (fetch).
- R2: In fetch (`state_code` 0) `mem_read` is high. With `mem_wait` low, `ir_load` and `pc_load` are high with `pc_src` 0 (PC+4), and the next state is decode (1).
- R3: In fetch, load-memory (9) or store-memory (12), a high `mem_wait` keeps the state unchanged. It also holds `ir_load`, `pc_load` and `mdr_load` low.
- R4: Decode dispatches on the 6-bit opcode. 0x23 (load) goes to 8, 0x2B (store) to 11, 0x00 (register-register) to 4, 0x0D (OR-immediate) to 6, 0x04 (branch-if-equal) to 2 and 0x02 (jump) to 3. Any other value goes to 13.
- R5: State 13 raises `epc_load` with the ALU set to PC minus 4 (`alu_a_pc` 1, `alu_b_sel` 1, `alu_op` 1). It also raises `cause_load` with `cause_code` 10 and `pc_load` with `pc_src` 3 (handler address), then returns to fetch.
- R6: In register-register execute (4), `alu_ovf` high leads to state 14 instead of write-back. State 14 performs the same save with `cause_code` 12, and no `reg_write` is issued for that instruction. `alu_ovf` has no effect in any other state.
- R7: An instruction boundary is the last cycle of states 2, 3, 5, 7 and 10, or state 12 with `mem_wait` low. At a boundary with `irq` and `irq_en` both high the next state is 15. State 15 performs the same save with `cause_code` 0. With `irq_en` low the request is ignored and fetch follows.
- R8: Decode computes the branch target (`alu_out_load` 1, `alu_a_pc` 1, `alu_b_sel` 3 = shifted sign-extended offset). In state 2 `pc_src` is 1 (ALU output register) and `pc_load` equals `alu_zero`.
- R9: State 3 raises `pc_load` with `pc_src` 2 (jump target), then reaches the boundary.
- R10: Load runs 8 → 9 → 10. State 9 raises `mem_read` with `mem_addr_alu` 1 and `mdr_load` once `mem_wait` is low. State 10 raises `reg_write` with `reg_from_mem` 1 and `reg_dst_rd` 0.
- R11: Store runs 11 → 12. State 12 raises `mem_write` with neither `mem_read` nor `reg_write`.
- R12: Register-register execute uses `alu_op` 2 (function field) with `alu_b_sel` 0. Its write-back (5) raises `reg_write` with `reg_dst_rd` 1. OR-immediate execute uses `alu_op` 3 with `alu_b_sel` 4 (zero-extended). Its write-back (7) raises `reg_write` with `reg_dst_rd` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | 6 | Opcode field of the instruction register |
| alu_ovf | input | 1 | Signed overflow from the ALU |
| alu_zero | input | 1 | ALU zero flag (operands equal on compare) |
| mem_wait | input | 1 | Memory not ready; stall the memory state |
| irq | input | 1 | External interrupt request |
| irq_en | input | 1 | Interrupt enable |
| ir_load | output | 1 | Load instruction register |
| pc_load | output | 1 | Load PC |
| pc_src | output | 2 | PC source: 0 PC+4, 1 ALU output reg, 2 jump target, 3 handler |
| mem_read | output | 1 | Memory read |
| mem_write | output | 1 | Memory write |
| mem_addr_alu | output | 1 | Memory address from ALU output reg (else PC) |
| mdr_load | output | 1 | Load memory data register |
| alu_a_pc | output | 1 | ALU A operand is PC (else register A) |
| alu_b_sel | output | 3 | ALU B: 0 reg B, 1 four, 2 sign-ext, 3 sign-ext shifted, 4 zero-ext |
| alu_op | output | 2 | ALU operation: 0 add, 1 subtract, 2 function field, 3 OR |
| alu_out_load | output | 1 | Load ALU output register |
| reg_write | output | 1 | Register file write |
| reg_dst_rd | output | 1 | Destination is rd (else rt) |
| reg_from_mem | output | 1 | Write data from memory data register |
| epc_load | output | 1 | Load exception PC from ALU (PC minus 4) |
| cause_load | output | 1 | Load cause register |
| cause_code | output | 5 | Cause value to load |
| state_code | output | 4 | Current state encoding |

## Verification
A wrong state register shows up on `state_code` and on the strobe set in the very next cycle, because every output is a flop loaded from the same next-state decode. A misrouted dispatch, stall or exception entry therefore appears one clock after the deciding input. A decode slip that picks the wrong select while keeping the state shows only as a wrong `pc_src`, `alu_b_sel` or `cause_code` in that single state. The bench compares those selects state by state. Gating faults on `mem_wait`, `alu_zero` or `rst` appear at once in the same cycle as a stray or missing load strobe.

// File: rtl/mcc_pkg.sv
package mcc_pkg;
  localparam int OPC_W   = 6;
  localparam int CAUSE_W = 5;
  localparam int ST_W    = 4;
  localparam int PCS_W   = 2;
  localparam int BSEL_W  = 3;
  localparam int AOP_W   = 2;

  typedef enum logic [ST_W-1:0] {
    ST_FETCH   = 4'h0,
    ST_DECODE  = 4'h1,
    ST_BEQ     = 4'h2,
    ST_JMP     = 4'h3,
    ST_R_EX    = 4'h4,
    ST_R_WB    = 4'h5,
    ST_ORI_EX  = 4'h6,
    ST_ORI_WB  = 4'h7,
    ST_LW_AD   = 4'h8,
    ST_LW_MEM  = 4'h9,
    ST_LW_WB   = 4'hA,
    ST_SW_AD   = 4'hB,
    ST_SW_MEM  = 4'hC,
    ST_X_UNDEF = 4'hD,
    ST_X_OVF   = 4'hE,
    ST_X_IRQ   = 4'hF
  } st_e;

  localparam logic [OPC_W-1:0] OP_RR  = 6'h00;
  localparam logic [OPC_W-1:0] OP_JMP = 6'h02;
  localparam logic [OPC_W-1:0] OP_BEQ = 6'h04;
  localparam logic [OPC_W-1:0] OP_ORI = 6'h0D;
  localparam logic [OPC_W-1:0] OP_LW  = 6'h23;
  localparam logic [OPC_W-1:0] OP_SW  = 6'h2B;

  localparam logic [PCS_W-1:0] PCS_INC = 2'd0;
  localparam logic [PCS_W-1:0] PCS_ALU = 2'd1;
  localparam logic [PCS_W-1:0] PCS_JMP = 2'd2;
  localparam logic [PCS_W-1:0] PCS_VEC = 2'd3;

  localparam logic [BSEL_W-1:0] BS_REG  = 3'd0;
  localparam logic [BSEL_W-1:0] BS_FOUR = 3'd1;
  localparam logic [BSEL_W-1:0] BS_SEXT = 3'd2;
  localparam logic [BSEL_W-1:0] BS_SSHL = 3'd3;
  localparam logic [BSEL_W-1:0] BS_ZEXT = 3'd4;

  localparam logic [AOP_W-1:0] AOP_ADD = 2'd0;
  localparam logic [AOP_W-1:0] AOP_SUB = 2'd1;
  localparam logic [AOP_W-1:0] AOP_FN  = 2'd2;
  localparam logic [AOP_W-1:0] AOP_OR  = 2'd3;

  typedef struct packed {
    logic               ir_ld;
    logic               pc_ld;
    logic               pc_ld_zero;
    logic               waitable;
    logic               mem_rd;
    logic               mem_wr;
    logic               addr_alu;
    logic               mdr_ld;
    logic               alu_a_pc;
    logic               alu_out_ld;
    logic               reg_wr;
    logic               reg_dst_rd;
    logic               wb_mem;
    logic               epc_ld;
    logic               cause_ld;
    logic [PCS_W-1:0]   pc_src;
    logic [BSEL_W-1:0]  b_sel;
    logic [AOP_W-1:0]   alu_op;
    logic [CAUSE_W-1:0] cause;
  } ctl_t;
endpackage

// File: rtl/mcc_next.sv
module mcc_next
  import mcc_pkg::*;
(
  input  st_e              cur,
  input  logic [OPC_W-1:0] opcode,
  input  logic             mem_wait,
  input  logic             alu_ovf,
  input  logic             irq_take,
  output st_e              nxt
);
  st_e dispatch;
  st_e retire;

  // Opcode dispatch out of decode
  always_comb begin
    case (opcode)
      OP_LW:   dispatch = ST_LW_AD;
      OP_SW:   dispatch = ST_SW_AD;
      OP_RR:   dispatch = ST_R_EX;
      OP_ORI:  dispatch = ST_ORI_EX;
      OP_BEQ:  dispatch = ST_BEQ;
      OP_JMP:  dispatch = ST_JMP;
      default: dispatch = ST_X_UNDEF;
    endcase
  end

  // Instruction boundary: pending enabled interrupt preempts the next fetch
  assign retire = irq_take ? ST_X_IRQ : ST_FETCH;

  always_comb begin
    nxt = cur;
    case (cur)
      ST_FETCH:   if (!mem_wait) nxt = ST_DECODE;
      ST_DECODE:  nxt = dispatch;
      ST_R_EX:    nxt = alu_ovf ? ST_X_OVF : ST_R_WB;
      ST_ORI_EX:  nxt = ST_ORI_WB;
      ST_LW_AD:   nxt = ST_LW_MEM;
      ST_LW_MEM:  if (!mem_wait) nxt = ST_LW_WB;
      ST_SW_AD:   nxt = ST_SW_MEM;
      ST_SW_MEM:  if (!mem_wait) nxt = retire;
      ST_R_WB, ST_ORI_WB, ST_LW_WB, ST_BEQ, ST_JMP: nxt = retire;
      default:    nxt = ST_FETCH;
    endcase
  end
endmodule

// File: rtl/mcc_decode.sv
module mcc_decode
  import mcc_pkg::*;
#(
  parameter logic [CAUSE_W-1:0] CAUSE_UNDEF = 5'd10,
  parameter logic [CAUSE_W-1:0] CAUSE_OVF   = 5'd12,
  parameter logic [CAUSE_W-1:0] CAUSE_IRQ   = 5'd0
) (
  input  st_e  st,
  output ctl_t c
);
  always_comb begin
    c = '0;
    case (st)
      ST_FETCH: begin
        c.ir_ld    = 1'b1;
        c.pc_ld    = 1'b1;
        c.waitable = 1'b1;
        c.mem_rd   = 1'b1;
        c.alu_a_pc = 1'b1;
        c.b_sel    = BS_FOUR;
        c.alu_op   = AOP_ADD;
        c.pc_src   = PCS_INC;
      end
      ST_DECODE: begin
        c.alu_a_pc   = 1'b1;
        c.b_sel      = BS_SSHL;
        c.alu_op     = AOP_ADD;
        c.alu_out_ld = 1'b1;
      end
      ST_BEQ: begin
        c.pc_ld_zero = 1'b1;
        c.pc_src     = PCS_ALU;
        c.b_sel      = BS_REG;
        c.alu_op     = AOP_SUB;
      end
      ST_JMP: begin
        c.pc_ld  = 1'b1;
        c.pc_src = PCS_JMP;
      end
      ST_R_EX: begin
        c.b_sel      = BS_REG;
        c.alu_op     = AOP_FN;
        c.alu_out_ld = 1'b1;
      end
      ST_R_WB: begin
        c.reg_wr     = 1'b1;
        c.reg_dst_rd = 1'b1;
      end
      ST_ORI_EX: begin
        c.b_sel      = BS_ZEXT;
        c.alu_op     = AOP_OR;
        c.alu_out_ld = 1'b1;
      end
      ST_ORI_WB: c.reg_wr = 1'b1;
      ST_LW_AD, ST_SW_AD: begin
        c.b_sel      = BS_SEXT;
        c.alu_op     = AOP_ADD;
        c.alu_out_ld = 1'b1;
      end
      ST_LW_MEM: begin
        c.mem_rd   = 1'b1;
        c.addr_alu = 1'b1;
        c.mdr_ld   = 1'b1;
        c.waitable = 1'b1;
      end
      ST_LW_WB: begin
        c.reg_wr = 1'b1;
        c.wb_mem = 1'b1;
      end
      ST_SW_MEM: begin
        c.mem_wr   = 1'b1;
        c.addr_alu = 1'b1;
        c.waitable = 1'b1;
      end
      ST_X_UNDEF, ST_X_OVF, ST_X_IRQ: begin
        c.alu_a_pc = 1'b1;
        c.b_sel    = BS_FOUR;
        c.alu_op   = AOP_SUB;
        c.epc_ld   = 1'b1;
        c.cause_ld = 1'b1;
        c.pc_ld    = 1'b1;
        c.pc_src   = PCS_VEC;
        c.cause    = (st == ST_X_UNDEF) ? CAUSE_UNDEF :
                     (st == ST_X_OVF)   ? CAUSE_OVF   : CAUSE_IRQ;
      end
      default: c = '0;
    endcase
  end
endmodule

// File: rtl/mc_ctrl_top.sv
module mc_ctrl_top
  import mcc_pkg::*;
#(
  parameter logic [CAUSE_W-1:0] CAUSE_UNDEF = 5'd10,
  parameter logic [CAUSE_W-1:0] CAUSE_OVF   = 5'd12,
  parameter logic [CAUSE_W-1:0] CAUSE_IRQ   = 5'd0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [OPC_W-1:0]   opcode,
  input  logic               alu_ovf,
  input  logic               alu_zero,
  input  logic               mem_wait,
  input  logic               irq,
  input  logic               irq_en,
  output logic               ir_load,
  output logic               pc_load,
  output logic [PCS_W-1:0]   pc_src,
  output logic               mem_read,
  output logic               mem_write,
  output logic               mem_addr_alu,
  output logic               mdr_load,
  output logic               alu_a_pc,
  output logic [BSEL_W-1:0]  alu_b_sel,
  output logic [AOP_W-1:0]   alu_op,
  output logic               alu_out_load,
  output logic               reg_write,
  output logic               reg_dst_rd,
  output logic               reg_from_mem,
  output logic               epc_load,
  output logic               cause_load,
  output logic [CAUSE_W-1:0] cause_code,
  output logic [ST_W-1:0]    state_code
);
  st_e  state_q;
  st_e  state_d;
  st_e  state_sel;
  ctl_t ctl_d;
  ctl_t ctl_q;
  logic hold;
  logic live;

  mcc_next u_next (
    .cur      (state_q),
    .opcode   (opcode),
    .mem_wait (mem_wait),
    .alu_ovf  (alu_ovf),
    .irq_take (irq & irq_en),
    .nxt      (state_d)
  );

  // Reset steers both the state and its decoded controls to fetch
  assign state_sel = rst ? ST_FETCH : state_d;

  mcc_decode #(
    .CAUSE_UNDEF (CAUSE_UNDEF),
    .CAUSE_OVF   (CAUSE_OVF),
    .CAUSE_IRQ   (CAUSE_IRQ)
  ) u_dec (
    .st (state_sel),
    .c  (ctl_d)
  );

  always_ff @(posedge clk) begin
    state_q <= state_sel;
    ctl_q   <= ctl_d;
  end

  assign live = ~rst;
  assign hold = ctl_q.waitable & mem_wait;

  assign ir_load      = live & ctl_q.ir_ld & ~hold;
  assign pc_load      = live & ((ctl_q.pc_ld & ~hold) | (ctl_q.pc_ld_zero & alu_zero));
  assign mdr_load     = live & ctl_q.mdr_ld & ~hold;
  assign mem_read     = live & ctl_q.mem_rd;
  assign mem_write    = live & ctl_q.mem_wr;
  assign reg_write    = live & ctl_q.reg_wr;
  assign alu_out_load = live & ctl_q.alu_out_ld;
  assign epc_load     = live & ctl_q.epc_ld;
  assign cause_load   = live & ctl_q.cause_ld;
  assign pc_src       = ctl_q.pc_src;
  assign mem_addr_alu = ctl_q.addr_alu;
  assign alu_a_pc     = ctl_q.alu_a_pc;
  assign alu_b_sel    = ctl_q.b_sel;
  assign alu_op       = ctl_q.alu_op;
  assign reg_dst_rd   = ctl_q.reg_dst_rd;
  assign reg_from_mem = ctl_q.wb_mem;
  assign cause_code   = ctl_q.cause;
  assign state_code   = state_q;
endmodule

// File: rtl/mc_ctrl_chk.sv
module mc_ctrl_chk
  import mcc_pkg::*;
#(
  parameter logic [CAUSE_W-1:0] CAUSE_UNDEF = 5'd10,
  parameter logic [CAUSE_W-1:0] CAUSE_OVF   = 5'd12,
  parameter logic [CAUSE_W-1:0] CAUSE_IRQ   = 5'd0
) (
  input logic               clk,
  input logic               rst,
  input logic [OPC_W-1:0]   opcode,
  input logic               mem_wait,
  input logic               alu_ovf,
  input logic               alu_zero,
  input logic               irq,
  input logic               irq_en,
  input logic [ST_W-1:0]    state_code,
  input logic               ir_load,
  input logic               pc_load,
  input logic [PCS_W-1:0]   pc_src,
  input logic               mdr_load,
  input logic               mem_read,
  input logic               mem_write,
  input logic               reg_write,
  input logic               epc_load,
  input logic               cause_load,
  input logic [CAUSE_W-1:0] cause_code
);
  logic at_edge;
  logic known_op;

  assign at_edge = (state_code inside {4'h2, 4'h3, 4'h5, 4'h7, 4'hA}) ||
                   (state_code == 4'hC && !mem_wait);
  assign known_op = opcode inside {OP_RR, OP_JMP, OP_BEQ, OP_ORI, OP_LW, OP_SW};

  // R1
  rst_quiet_chk: assert property (@(posedge clk)
    rst |-> !(ir_load || pc_load || mdr_load || mem_read || mem_write ||
              reg_write || epc_load || cause_load));

  // R2
  fetch_adv_chk: assert property (@(posedge clk) disable iff (rst)
    (state_code == 4'h0 && !mem_wait) |=> state_code == 4'h1);

  // R3
  wait_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ((state_code == 4'h0 || state_code == 4'h9 || state_code == 4'hC) && mem_wait)
    |=> state_code == $past(state_code));

  // R3
  wait_noload_chk: assert property (@(posedge clk) disable iff (rst)
    ((state_code == 4'h0 || state_code == 4'h9) && mem_wait)
    |-> !ir_load && !pc_load && !mdr_load);

  // R4
  undef_route_chk: assert property (@(posedge clk) disable iff (rst)
    (state_code == 4'h1 && !known_op) |=> state_code == 4'hD);

  // R5
  undef_save_chk: assert property (@(posedge clk) disable iff (rst)
    state_code == 4'hD |-> epc_load && cause_load && pc_load &&
                           pc_src == PCS_VEC && cause_code == CAUSE_UNDEF);

  // R6
  ovf_route_chk: assert property (@(posedge clk) disable iff (rst)
    (state_code == 4'h4 && alu_ovf) |=> state_code == 4'hE && !reg_write);

  // R6
  ovf_save_chk: assert property (@(posedge clk) disable iff (rst)
    state_code == 4'hE |-> cause_load && cause_code == CAUSE_OVF && !reg_write);

  // R7
  irq_take_chk: assert property (@(posedge clk) disable iff (rst)
    (at_edge && irq && irq_en) |=> state_code == 4'hF && cause_code == CAUSE_IRQ);

  // R7
  irq_mask_chk: assert property (@(posedge clk) disable iff (rst)
    (at_edge && !irq_en) |=> state_code == 4'h0);

  // R8
  beq_zero_chk: assert property (@(posedge clk) disable iff (rst)
    state_code == 4'h2 |-> pc_load == alu_zero && pc_src == PCS_ALU);

  // R11
  store_only_chk: assert property (@(posedge clk) disable iff (rst)
    state_code == 4'hC |-> mem_write && !mem_read && !reg_write);
endmodule

bind mc_ctrl_top mc_ctrl_chk #(
  .CAUSE_UNDEF (CAUSE_UNDEF),
  .CAUSE_OVF   (CAUSE_OVF),
  .CAUSE_IRQ   (CAUSE_IRQ)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .opcode     (opcode),
  .mem_wait   (mem_wait),
  .alu_ovf    (alu_ovf),
  .alu_zero   (alu_zero),
  .irq        (irq),
  .irq_en     (irq_en),
  .state_code (state_code),
  .ir_load    (ir_load),
  .pc_load    (pc_load),
  .pc_src     (pc_src),
  .mdr_load   (mdr_load),
  .mem_read   (mem_read),
  .mem_write  (mem_write),
  .reg_write  (reg_write),
  .epc_load   (epc_load),
  .cause_load (cause_load),
  .cause_code (cause_code)
);

// File: tb/mc_ctrl_top_tb_top.sv
module mc_ctrl_top_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] opcode = 6'h00;
  logic       alu_ovf = 1'b0, alu_zero = 1'b0, mem_wait = 1'b0, irq = 1'b0, irq_en = 1'b0;
  logic       ir_load, pc_load, mem_read, mem_write, mem_addr_alu, mdr_load, alu_a_pc;
  logic       alu_out_load, reg_write, reg_dst_rd, reg_from_mem, epc_load, cause_load;
  logic [1:0] pc_src, alu_op;
  logic [2:0] alu_b_sel;
  logic [4:0] cause_code;
  logic [3:0] state_code;

  int nchk = 0;
  int nbad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  mc_ctrl_top dut_i (
    .clk(clk), .rst(rst), .opcode(opcode), .alu_ovf(alu_ovf), .alu_zero(alu_zero),
    .mem_wait(mem_wait), .irq(irq), .irq_en(irq_en), .ir_load(ir_load), .pc_load(pc_load),
    .pc_src(pc_src), .mem_read(mem_read), .mem_write(mem_write), .mem_addr_alu(mem_addr_alu),
    .mdr_load(mdr_load), .alu_a_pc(alu_a_pc), .alu_b_sel(alu_b_sel), .alu_op(alu_op),
    .alu_out_load(alu_out_load), .reg_write(reg_write), .reg_dst_rd(reg_dst_rd),
    .reg_from_mem(reg_from_mem), .epc_load(epc_load), .cause_load(cause_load),
    .cause_code(cause_code), .state_code(state_code)
  );

  typedef struct packed {
    logic [5:0] op;
    logic       ovf, zero, wt, rq, en;
    logic [3:0] st;
    logic [6:0] str;   // {ir_load,pc_load,mem_read,mem_write,reg_write,epc_load,cause_load}
    logic [1:0] ps;
    logic [4:0] cz;
    logic [3:0] req;
  } vec_t;

  localparam logic [5:0] OR_ = 6'h00, OL = 6'h23, OS = 6'h2B, OB = 6'h04,
                         OJ = 6'h02, OI = 6'h0D, OX = 6'h3F;
  localparam logic [6:0] FE = 7'b1110000, RW = 7'b0000100, MR = 7'b0010000,
                         MW = 7'b0001000, PL = 7'b0100000, EX = 7'b0100011, NO = 7'b0;
  localparam int NV = 39;

  // Each row: inputs for this cycle, state expected during it, strobes, pc_src, cause
  localparam vec_t VECS [NV] = '{
    '{OR_,1'b0,1'b0,1'b0,1'b0,1'b0,4'h0,FE,2'd0,5'd0,4'd2},   // R2 fetch
    '{OR_,1'b0,1'b0,1'b0,1'b0,1'b0,4'h1,NO,2'd0,5'd0,4'd4},   // R4 reg-reg
    '{OR_,1'b0,1'b0,1'b0,1'b0,1'b0,4'h4,NO,2'd0,5'd0,4'd12},
    '{OR_,1'b0,1'b0,1'b0,1'b0,1'b0,4'h5,RW,2'd0,5'd0,4'd12},  // R12
    '{OR_,1'b0,1'b0,1'b1,1'b0,1'b0,4'h0,MR,2'd0,5'd0,4'd3},   // R3 fetch stall
    '{OR_,1'b0,1'b0,1'b1,1'b0,1'b0,4'h0,MR,2'd0,5'd0,4'd3},
    '{OR_,1'b0,1'b0,1'b0,1'b0,1'b0,4'h0,FE,2'd0,5'd0,4'd2},
    '{OL ,1'b0,1'b0,1'b0,1'b0,1'b0,4'h1,NO,2'd0,5'd0,4'd4},   // R4 load
    '{OL ,1'b0,1'b0,1'b0,1'b0,1'b0,4'h8,NO,2'd0,5'd0,4'd10},
    '{OL ,1'b0,1'b0,1'b1,1'b0,1'b0,4'h9,MR,2'd0,5'd0,4'd3},   // R3 data stall
    '{OL ,1'b0,1'b0,1'b0,1'b0,1'b0,4'h9,MR,2'd0,5'd0,4'd10},
    '{OL ,1'b0,1'b0,1'b0,1'b1,1'b0,4'hA,RW,2'd0,5'd0,4'd7},   // R7 masked
    '{OL ,1'b0,1'b0,1'b0,1'b1,1'b0,4'h0,FE,2'd0,5'd0,4'd7},
    '{OS ,1'b0,1'b0,1'b0,1'b0,1'b0,4'h1,NO,2'd0,5'd0,4'd4},   // R4 store
    '{OS ,1'b0,1'b0,1'b0,1'b0,1'b0,4'hB,NO,2'd0,5'd0,4'd11},
    '{OS ,1'b0,1'b0,1'b1,1'b0,1'b0,4'hC,MW,2'd0,5'd0,4'd3},   // R3 store stall
    '{OS ,1'b0,1'b0,1'b0,1'b1,1'b1,4'hC,MW,2'd0,5'd0,4'd11},  // R11
    '{OS ,1'b0,1'b0,1'b0,1'b0,1'b0,4'hF,EX,2'd3,5'd0,4'd7},   // R7 taken
    '{OS ,1'b0,1'b0,1'b0,1'b0,1'b0,4'h0,FE,2'd0,5'd0,4'd7},
    '{OB ,1'b0,1'b0,1'b0,1'b0,1'b0,4'h1,NO,2'd0,5'd0,4'd4},   // R4 branch
    '{OB ,1'b0,1'b1,1'b0,1'b0,1'b0,4'h2,PL,2'd1,5'd0,4'd8},   // R8 taken
    '{OB ,1'b0,1'b0,1'b0,1'b0,1'b0,4'h0,FE,2'd0,5'd0,4'd8},
    '{OB ,1'b0,1'b0,1'b0,1'b0,1'b0,4'h1,NO,2'd0,5'd0,4'd4},
    '{OB ,1'b0,1'b0,1'b0,1'b0,1'b0,4'h2,NO,2'd1,5'd0,4'd8},   // R8 not taken
    '{OB ,1'b0,1'b0,1'b0,1'b0,1'b0,4'h0,FE,2'd0,5'd0,4'd8},
    '{OJ ,1'b0,1'b0,1'b0,1'b0,1'b0,4'h1,NO,2'd0,5'd0,4'd4},   // R4 jump
    '{OJ ,1'b0,1'b0,1'b0,1'b0,1'b0,4'h3,PL,2'd2,5'd0,4'd9},   // R9
    '{OJ ,1'b0,1'b0,1'b0,1'b0,1'b0,4'h0,FE,2'd0,5'd0,4'd9},
    '{OI ,1'b0,1'b0,1'b0,1'b0,1'b0,4'h1,NO,2'd0,5'd0,4'd4},   // R4 ori
    '{OI ,1'b1,1'b0,1'b0,1'b0,1'b0,4'h6,NO,2'd0,5'd0,4'd6},   // R6 ovf ignored
    '{OI ,1'b0,1'b0,1'b0,1'b0,1'b0,4'h7,RW,2'd0,5'd0,4'd6},
    '{OI ,1'b0,1'b0,1'b0,1'b0,1'b0,4'h0,FE,2'd0,5'd0,4'd12},
    '{OX ,1'b0,1'b0,1'b0,1'b0,1'b0,4'h1,NO,2'd0,5'd0,4'd4},   // R4 undefined
    '{OX ,1'b0,1'b0,1'b0,1'b0,1'b0,4'hD,EX,2'd3,5'd10,4'd5},  // R5
    '{OX ,1'b0,1'b0,1'b0,1'b0,1'b0,4'h0,FE,2'd0,5'd0,4'd5},
    '{OR_,1'b0,1'b0,1'b0,1'b0,1'b0,4'h1,NO,2'd0,5'd0,4'd4},
    '{OR_,1'b1,1'b0,1'b0,1'b0,1'b0,4'h4,NO,2'd0,5'd0,4'd6},   // R6 overflow
    '{OR_,1'b0,1'b0,1'b0,1'b0,1'b0,4'hE,EX,2'd3,5'd12,4'd6},
    '{OR_,1'b0,1'b0,1'b0,1'b0,1'b0,4'h0,FE,2'd0,5'd0,4'd6}
  };

  task automatic chk(input string rq, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nbad++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic drive(input logic r, input logic [5:0] op, input logic ovf, input logic z,
                       input logic wt, input logic rq, input logic en);
    @(negedge clk);
    rst = r; opcode = op; alu_ovf = ovf; alu_zero = z; mem_wait = wt; irq = rq; irq_en = en;
    #1;
  endtask

  function automatic int strobes();
    return int'({ir_load, pc_load, mem_read, mem_write, reg_write, epc_load, cause_load});
  endfunction

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    // R1 reset state
    chk("R1 reset state", int'(state_code), 0);
    chk("R1 reset strobes", strobes() | int'(mdr_load) | int'(alu_out_load), 0);

    for (int i = 0; i < NV; i++) begin
      drive(1'b0, VECS[i].op, VECS[i].ovf, VECS[i].zero, VECS[i].wt, VECS[i].rq, VECS[i].en);
      chk($sformatf("R%0d step %0d state", VECS[i].req, i), int'(state_code), int'(VECS[i].st));
      chk($sformatf("R%0d step %0d strobes", VECS[i].req, i), strobes(), int'(VECS[i].str));
      chk($sformatf("R%0d step %0d pc_src", VECS[i].req, i), int'(pc_src), int'(VECS[i].ps));
      chk($sformatf("R%0d step %0d cause", VECS[i].req, i), int'(cause_code), int'(VECS[i].cz));
    end

    // Directed: decode target setup (R8)
    drive(1'b0, OL, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R8 decode state", int'(state_code), 1);
    chk("R8 target load", int'({alu_out_load, alu_a_pc, alu_b_sel}), int'({1'b1, 1'b1, 3'd3}));
    drive(1'b0, OL, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R10 address state", int'(state_code), 8);
    drive(1'b0, OL, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    chk("R3 mdr held on wait", int'(mdr_load), 0);
    drive(1'b0, OL, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R10 mdr load", int'({mdr_load, mem_addr_alu}), 3);
    drive(1'b0, OL, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
    chk("R10 load writeback", int'({reg_write, reg_from_mem, reg_dst_rd}), int'(3'b110));
    drive(1'b0, OL, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R7 irq after load", int'(state_code), 15);
    chk("R5 epc minus four", int'({alu_a_pc, alu_b_sel, alu_op}), int'({1'b1, 3'd1, 2'd1}));
    drive(1'b0, OI, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R7 back to fetch", int'(state_code), 0);
    drive(1'b0, OI, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    drive(1'b0, OI, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R12 ori execute", int'({state_code, alu_b_sel, alu_op}), int'({4'h6, 3'd4, 2'd3}));
    drive(1'b0, OI, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R12 ori dest rt", int'({reg_write, reg_dst_rd}), 2);
    drive(1'b0, OR_, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    drive(1'b0, OR_, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    drive(1'b0, OR_, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R12 rr execute", int'({state_code, alu_b_sel, alu_op, alu_out_load}),
        int'({4'h4, 3'd0, 2'd2, 1'b1}));
    drive(1'b0, OR_, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R12 rr dest rd", int'({reg_write, reg_dst_rd}), 3);

    // Directed: reset in the middle of a load (R1)
    drive(1'b0, OL, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    drive(1'b0, OL, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    drive(1'b0, OL, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    drive(1'b1, OL, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R1 mid-load state", int'(state_code), 9);
    chk("R1 strobes gated", int'({mem_read, mdr_load}), 0);
    drive(1'b1, OL, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R1 reset to fetch", int'(state_code), 0);
    chk("R1 fetch quiet in reset", strobes(), 0);
    drive(1'b0, OL, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R2 fetch after release", strobes(), int'(FE));

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

  initial begin
    repeat (3000) @(posedge clk);
    if (!done) begin
      nchk++;
      nbad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
    end
  end
endmodule